// File: doc/BRIEF.md
# 100BASE-X PCS Transmit Encoder

This block turns the nibble-wide transmit side of a media-independent interface into the 5-bit code-group stream that feeds a 100 Mb/s line driver. On every clock it emits one code-group. Between frames it sends the idle code. When transmit enable rises, the two leading preamble nibbles are dropped and replaced by the two halves of the start-of-stream delimiter. Every later nibble is mapped through the 4B/5B data table. When enable drops, the end-of-stream delimiter pair is sent, and then idle resumes.

The block also derives the carrier-sense and collision indications. Carrier sense is the OR of local transmit activity and a receive-activity input. Collision is their overlap. All outputs are registered, so each output reflects the inputs sampled one clock earlier. Scrambling, line coding, serialization and the receive path belong to other blocks.

Top module: `fx_tx_pcs_enc`

## Requirements
- R1: While `rst` is high, on each clock `code_o` becomes 11111, and `crs_o` and `col_o` become 0.
- R2: While no frame is in progress and `tx_en` is low, the clock edge that samples it produces `code_o` = 11111 (IDLE).
- R3: The edge that first samples `tx_en` high outside a frame produces 11000 (J), and the next edge produces 10001 (K). The `txd` values of those two cycles are discarded.
- R4: After K, every edge that samples `tx_en` high produces the 4B/5B code of `txd`: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: After K, the first edge that samples `tx_en` low produces 01101 (T). The next edge produces 00111 (R). Normal idle handling resumes after that.
- R6: A frame whose `tx_en` is high for only one or two cycles still produces the full sequence J, K, T, R.
- R7: `tx_en` sampled on the edge that produces R is ignored. If it is still high on the following edge, that edge produces J.
- R8: `crs_o` equals `tx_en | rx_act` as sampled on the previous edge.
- R9: `col_o` equals `tx_en & rx_act` as sampled on the previous edge, so it stays high for exactly the overlap, shifted by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit nibble clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| txd | input | 4 | Transmit nibble from the MAC |
| rx_act | input | 1 | Receive activity from the receive path |
| code_o | output | 5 | Code-group to the line driver |
| crs_o | output | 1 | Carrier sense |
| col_o | output | 1 | Collision indication |

## Verification
A wrong frame phase shows up on `code_o` one clock later. Possible symptoms are a missing or doubled delimiter half, a data code where T or R belongs, or idle in the middle of a frame. The scoreboard compares every cycle, so the first misplaced code-group is caught on the edge that produces it. Carrier and collision are combined from two inputs with no state, so an error there shows on the very next edge. Random overlaps of receive activity with frames expose it within a few cycles.

// File: rtl/fx_tx_pkg.sv
package fx_tx_pkg;
  localparam int NIB_W = 4;
  localparam int CG_W  = 5;

  typedef logic [CG_W-1:0]  cg_t;
  typedef logic [NIB_W-1:0] nib_t;

  localparam cg_t CG_IDLE = 5'b11111;
  localparam cg_t CG_J    = 5'b11000;
  localparam cg_t CG_K    = 5'b10001;
  localparam cg_t CG_T    = 5'b01101;
  localparam cg_t CG_R    = 5'b00111;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SSD2 = 2'd1,
    PH_DATA = 2'd2,
    PH_ESD2 = 2'd3
  } phase_t;

  function automatic cg_t data_cg(input nib_t n);
    cg_t c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/fx_nib_map.sv
module fx_nib_map
  import fx_tx_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  output logic [CG_W-1:0]  cg_o
);
  always_comb cg_o = data_cg(nib_i);

  always_comb begin
    AST_DATA_NOT_CTRL: assert (cg_o != CG_IDLE && cg_o != CG_J && cg_o != CG_K &&
                               cg_o != CG_T && cg_o != CG_R); // R4
  end
endmodule

// File: rtl/fx_tx_seq.sv
module fx_tx_seq
  import fx_tx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tx_en,
  input  logic [CG_W-1:0] data_cg_i,
  output logic [CG_W-1:0] code_q
);
  phase_t ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      code_q <= CG_IDLE;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (tx_en) begin
            code_q <= CG_J;
            ph     <= PH_SSD2;
          end else begin
            code_q <= CG_IDLE;
          end
        end
        PH_SSD2: begin
          code_q <= CG_K;
          ph     <= PH_DATA;
        end
        PH_DATA: begin
          if (tx_en) begin
            code_q <= data_cg_i;
          end else begin
            code_q <= CG_T;
            ph     <= PH_ESD2;
          end
        end
        default: begin
          code_q <= CG_R;
          ph     <= PH_IDLE;
        end
      endcase
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> code_q == CG_IDLE); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IDLE && !tx_en) |=> code_q == CG_IDLE); // R2
  AST_J_THEN_K: assert property (@(posedge clk) disable iff (rst)
    (code_q == CG_J) |=> code_q == CG_K); // R3
  AST_T_THEN_R: assert property (@(posedge clk) disable iff (rst)
    (code_q == CG_T) |=> code_q == CG_R); // R5
  AST_R_THEN_START_OR_IDLE: assert property (@(posedge clk) disable iff (rst)
    (code_q == CG_R) |=> (code_q == CG_IDLE || code_q == CG_J)); // R7
endmodule

// File: rtl/fx_carrier_ctl.sv
module fx_carrier_ctl (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic rx_act,
  output logic crs_q,
  output logic col_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      crs_q <= 1'b0;
      col_q <= 1'b0;
    end else begin
      crs_q <= tx_en | rx_act;
      col_q <= tx_en & rx_act;
    end
  end

  AST_COL_IMPLIES_CRS: assert property (@(posedge clk) disable iff (rst)
    col_q |-> crs_q); // R9
  AST_COL_FOLLOWS_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    (tx_en && rx_act) |=> col_q); // R9
  AST_CRS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && !rx_act) |=> !crs_q); // R8
endmodule

// File: rtl/fx_tx_pcs_enc.sv
module fx_tx_pcs_enc
  import fx_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic [NIB_W-1:0] txd,
  input  logic             rx_act,
  output logic [CG_W-1:0]  code_o,
  output logic             crs_o,
  output logic             col_o
);
  logic [CG_W-1:0] mapped_cg;

  fx_nib_map u_map (
    .nib_i (txd),
    .cg_o  (mapped_cg)
  );

  fx_tx_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .data_cg_i (mapped_cg),
    .code_q    (code_o)
  );

  fx_carrier_ctl u_car (
    .clk    (clk),
    .rst    (rst),
    .tx_en  (tx_en),
    .rx_act (rx_act),
    .crs_q  (crs_o),
    .col_q  (col_o)
  );
endmodule

// File: tb/fx_tx_pcs_enc_tb_top.sv
module fx_tx_pcs_enc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  typedef struct {
    logic [4:0] code;
    logic       crs;
    logic       col;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       rx_act = 1'b0;
  logic [4:0] code_o;
  logic       crs_o, col_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t sb_q[$];

  int m_ph = 0;
  int m_len = 0;
  bit m_after_r = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fx_tx_pcs_enc dut_i (
    .clk(clk), .rst(rst), .tx_en(tx_en), .txd(txd), .rx_act(rx_act),
    .code_o(code_o), .crs_o(crs_o), .col_o(col_o)
  );

  function automatic logic [4:0] ref_code(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic [3:0] d, input logic act);
    exp_t e;
    @(negedge clk);
    tx_en = en; txd = d; rx_act = act;
    e.crs = en | act;
    e.col = en & act;
    case (m_ph)
      0: begin
        if (en) begin
          e.code = 5'b11000; e.tag = m_after_r ? "R7" : "R3"; m_ph = 1; m_len = 1;
        end else begin
          e.code = 5'b11111; e.tag = "R2";
        end
        m_after_r = 0;
      end
      1: begin
        e.code = 5'b10001; e.tag = "R3"; m_ph = 2;
        if (en) m_len++;
      end
      2: begin
        if (en) begin
          e.code = ref_code(d); e.tag = "R4"; m_len++;
        end else begin
          e.code = 5'b01101; e.tag = (m_len <= 2) ? "R6" : "R5"; m_ph = 3;
        end
      end
      default: begin
        e.code = 5'b00111; e.tag = (m_len <= 2) ? "R6" : "R5"; m_ph = 0; m_after_r = 1;
      end
    endcase
    sb_q.push_back(e);
  endtask

  always begin
    exp_t e;
    @(posedge clk);
    #1;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      check(e.tag, {3'b000, code_o}, {3'b000, e.code});
      check("R8", {7'b0, crs_o}, {7'b0, e.crs});
      check("R9", {7'b0, col_o}, {7'b0, e.col});
    end
  end

  task automatic frame(input int n, input int gap, input bit act_mode);
    for (int i = 0; i < n; i++)
      step(1'b1, 4'($urandom_range(0, 15)), act_mode ? 1'($urandom_range(0, 1)) : 1'b0);
    for (int i = 0; i < gap; i++)
      step(1'b0, 4'($urandom_range(0, 15)), act_mode ? 1'($urandom_range(0, 1)) : 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {3'b000, code_o}, 8'b00011111);
    check("R1", {6'b0, crs_o, col_o}, 8'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: idle stream
    for (int i = 0; i < 5; i++) step(1'b0, 4'hA, 1'b0);
    // R4: sweep every nibble
    step(1'b1, 4'h5, 1'b0); step(1'b1, 4'hD, 1'b0);
    for (int i = 0; i < 16; i++) step(1'b1, 4'(i), 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 4'h0, 1'b0);
    // R6: one-cycle and two-cycle frames
    frame(1, 4, 0);
    frame(2, 4, 0);
    // R7: enable high during the R cycle
    frame(5, 1, 0);
    frame(4, 3, 0);
    // R9: collision window inside a frame
    step(1'b1, 4'h1, 1'b0); step(1'b1, 4'h2, 1'b0);
    step(1'b1, 4'h3, 1'b1); step(1'b1, 4'h4, 1'b1); step(1'b1, 4'h5, 1'b1);
    step(1'b1, 4'h6, 1'b0); step(1'b0, 4'h0, 1'b1); step(1'b0, 4'h0, 1'b0);
    step(1'b0, 4'h0, 1'b0); step(1'b0, 4'h0, 1'b0);
    // random frames with random gaps and receive activity
    for (int f = 0; f < 200; f++)
      frame($urandom_range(1, 20), $urandom_range(1, 6), 1);
    for (int i = 0; i < 4; i++) step(1'b0, 4'h0, 1'b0);
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1-R9 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule